// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous SRAM model whose command pipeline keeps the data bus busy in every cycle. Address, chip selects, read/write select and byte write strobes are registered on each enabled clock edge. Write data is taken from the bus at the same command-to-data distance that read data is returned. A stream of reads and writes in any order therefore occupies consecutive bus cycles with no idle gap between them. The storage array is small and parameterised. The bidirectional data bus is split into a data-in port, a data-out port and an output-drive flag.

The read/write distance is two enabled edges in pipelined mode and one in flow-through mode. The mode is taken from `flow_i` while reset is held. A burst-advance input repeats the previous operation at the next address of a four-beat wrapping sequence. That sequence is either linear or interleaved. A clock-enable input freezes the whole block. Writes are committed to the array only when their delayed data arrives. In pipelined mode, a read that follows a write to the same word sees the merged new bytes.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_ni` is low, and after reset, `data_oe_o` is low and `data_o` is zero until a read reaches its bus cycle. Every word of the array reads as zero after reset.
- R2: Pipelined mode (`flow_i` low during reset): a read sampled at enabled edge k drives the word on `data_o` during the cycle that ends at enabled edge k+2.
- R3: Flow-through mode (`flow_i` high during reset): a read sampled at enabled edge k drives the word during the cycle that ends at enabled edge k+1.
- R4: A write sampled at enabled edge k takes `data_i` at enabled edge k+2 in pipelined mode and at edge k+1 in flow-through mode. Reads and writes in any order run in consecutive cycles without idle bus cycles.
- R5: `be_ni` is active low. Byte j of a write updates data bits [8j+7:8j] only when `be_ni[j]` is 0 at the command edge (load or burst beat). The other bytes keep their old value.
- R6: A load with `cs0_ni` high, `cs1_i` low or `cs2_ni` high is a deselect. It writes nothing, and its bus cycle is not driven.
- R7: With `adv_i` high, the address, chip selects and `rnw_i` are ignored, and the previous operation (read, write or deselect) repeats at the next burst address. The upper address bits stay fixed. Beat n (n = 1..3, wrapping) sets the low two bits to start+n mod 4 when `lin_i` is 1, or to start XOR n when `lin_i` is 0.
- R8: With `cken_ni` high, nothing advances: no command is taken, no write commits, `data_i` is ignored, and `data_o`/`data_oe_o` hold.
- R9: `oe_ni` high forces `data_oe_o` low and `data_o` to zero at once, without a clock. It has no effect on writes.
- R10: In pipelined mode, a read issued one edge after a write to the same address returns the new bytes merged over the old word.
- R11: Changes on `flow_i` after reset is released do not change the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; mode captured while low |
| flow_i | input | 1 | 1 = flow-through, 0 = pipelined (sampled during reset) |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved (hold static) |
| cken_ni | input | 1 | Active-low clock enable |
| adv_i | input | 1 | 1 = burst advance, 0 = load new command |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| rnw_i | input | 1 | 1 = read, 0 = write on load |
| be_ni | input | NB | Active-low byte write strobes |
| addr_i | input | AW | Word address |
| data_i | input | NB*BW | Write data bus |
| oe_ni | input | 1 | Asynchronous active-low output enable |
| data_o | output | NB*BW | Read data, zero when not driven |
| data_oe_o | output | 1 | High while the block drives the bus |

## Verification
Most internal faults in this block show at the ports within one or two bus cycles. A pipeline stage that is skipped or duplicated moves read data and the drive flag by one cycle. A lost or misrouted write commit shows only on the next read of that word, possibly many cycles later. A wrong burst step returns a neighbour word on the following beat. A missing bypass returns the stale word for a read that directly follows a write to the same word. The bench therefore compares the driven flag and the data on every cycle, and it re-reads written words later to expose wrong commits.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_ctr.sv
`timescale 1ns/1ps
module zbt_burst_ctr #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          lin_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q, cnt_nx, low;

  assign cnt_nx = cnt_q + BB'(1);
  assign low    = lin_i ? (base_q[BB-1:0] + cnt_nx) : (base_q[BB-1:0] ^ cnt_nx);
  assign addr_o = load_i ? addr_i : {base_q[AW-1:BB], low};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/zbt_cmd_pipe.sv
`timescale 1ns/1ps
module zbt_cmd_pipe #(
  parameter int CW     = 10,
  parameter int STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [CW-1:0]                cmd_i,
  output logic [STAGES-1:0][CW-1:0]    stage_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [CW-1:0] q;
    logic [CW-1:0] d;
    if (s == 0) begin : g_head
      assign d = cmd_i;
    end else begin : g_tail
      assign d = g_st[s-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= '0;   // all-zero is an idle command
      else if (en_i) q <= d;
    end
    assign stage_o[s] = q;
  end
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [NB*BW-1:0] wdata_i,
  input  logic [NB-1:0]    wbe_ni,
  input  logic [AW-1:0]    raddr_i,
  output logic [NB*BW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
      end else if (we_i && !wbe_ni[b]) begin
        lane_q[waddr_i] <= wdata_i[b*BW +: BW];
      end
    end
    assign rdata_o[b*BW +: BW] = lane_q[raddr_i];
  end
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8,
  parameter int BB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flow_i,
  input  logic             lin_i,
  input  logic             cken_ni,
  input  logic             adv_i,
  input  logic             cs0_ni,
  input  logic             cs1_i,
  input  logic             cs2_ni,
  input  logic             rnw_i,
  input  logic [NB-1:0]    be_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB*BW-1:0] data_i,
  input  logic             oe_ni,
  output logic [NB*BW-1:0] data_o,
  output logic             data_oe_o
);
  localparam int DW     = NB * BW;
  localparam int OPW    = $bits(op_e);
  localparam int CW     = OPW + AW + NB;
  localparam int STAGES = 2;

  logic en, load, cs_ok, flow_q;
  op_e  last_q, cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [STAGES-1:0][CW-1:0] stage;

  assign en    = ~cken_ni;
  assign load  = ~adv_i;
  assign cs_ok = ~cs0_ni & cs1_i & ~cs2_ni;

  // mode is static: captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) flow_q <= flow_i;
  end

  always_comb begin
    if (load) cmd_op = !cs_ok ? OP_IDLE : (rnw_i ? OP_RD : OP_WR);
    else      cmd_op = last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= OP_IDLE;
    else if (en)  last_q <= cmd_op;
  end

  zbt_burst_ctr #(.AW(AW), .BB(BB)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (load),
    .lin_i  (lin_i),
    .addr_i (addr_i),
    .addr_o (cmd_addr)
  );

  zbt_cmd_pipe #(.CW(CW), .STAGES(STAGES)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .cmd_i   ({cmd_op, cmd_addr, be_ni}),
    .stage_o (stage)
  );

  op_e op1, op2, bus_op;
  logic [AW-1:0] a1, a2, bus_addr;
  logic [NB-1:0] be1, be2, bus_be;

  assign op1 = op_e'(stage[0][CW-1 -: OPW]);
  assign a1  = stage[0][NB +: AW];
  assign be1 = stage[0][NB-1:0];
  assign op2 = op_e'(stage[1][CW-1 -: OPW]);
  assign a2  = stage[1][NB +: AW];
  assign be2 = stage[1][NB-1:0];

  // bus-cycle owner: one stage back in flow-through, two in pipelined
  assign bus_op   = flow_q ? op1 : op2;
  assign bus_addr = flow_q ? a1  : a2;
  assign bus_be   = flow_q ? be1 : be2;

  logic [DW-1:0] rd, fwd, out_q;

  zbt_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en && bus_op == OP_WR),
    .waddr_i (bus_addr),
    .wdata_i (data_i),
    .wbe_ni  (bus_be),
    .raddr_i (a1),
    .rdata_o (rd)
  );

  // bypass the write that commits on the same edge the read is registered
  always_comb begin
    fwd = rd;
    if (op2 == OP_WR && a2 == a1) begin
      for (int b = 0; b < NB; b++) begin
        if (!be2[b]) fwd[b*BW +: BW] = data_i[b*BW +: BW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  out_q <= '0;
    else if (en)  out_q <= fwd;
  end

  assign data_oe_o = ~oe_ni & (bus_op == OP_RD);
  assign data_o    = data_oe_o ? (flow_q ? rd : out_q) : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cken_ni,
  input logic          adv_i,
  input logic          cs0_ni,
  input logic          cs1_i,
  input logic          cs2_ni,
  input logic          rnw_i,
  input logic          oe_ni,
  input logic          flow_q,
  input logic          data_oe_o,
  input logic [DW-1:0] data_o
);
  logic cs_ok;
  assign cs_ok = ~cs0_ni & cs1_i & ~cs2_ni;

  assert_quiet_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !data_oe_o);

  assert_pipe_read_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_q && !cken_ni && !adv_i && cs_ok && rnw_i) ##1 !cken_ni |=> (oe_ni || data_oe_o));

  assert_flow_read_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_q && !cken_ni && !adv_i && cs_ok && rnw_i) |=> (oe_ni || data_oe_o));

  assert_dsel_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_q && !cken_ni && !adv_i && !cs_ok) ##1 !cken_ni |=> !data_oe_o);

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cken_ni ##1 $stable(oe_ni) |-> ($stable(data_o) && $stable(data_oe_o)));

  assert_oe_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!data_oe_o && data_o == '0));

  assert_mode_static_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(flow_q));
endmodule

bind zbt_sram zbt_sram_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cken_ni   (cken_ni),
  .adv_i     (adv_i),
  .cs0_ni    (cs0_ni),
  .cs1_i     (cs1_i),
  .cs2_ni    (cs2_ni),
  .rnw_i     (rnw_i),
  .oe_ni     (oe_ni),
  .flow_q    (flow_q),
  .data_oe_o (data_oe_o),
  .data_o    (data_o)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
  localparam int AW = 6, NB = 2, BW = 8, DW = NB * BW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0, flow_i = 1'b0, lin_i = 1'b1;
  logic cken_ni = 1'b0, adv_i = 1'b0, cs0_ni = 1'b1, cs1_i = 1'b0, cs2_ni = 1'b1;
  logic rnw_i = 1'b1, oe_ni = 1'b0;
  logic [NB-1:0] be_ni = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0, data_o;
  logic data_oe_o;

  zbt_sram #(.AW(AW), .NB(NB), .BW(BW)) u_zbt_sram (
    .clk_i(clk), .rst_ni(rst_ni), .flow_i(flow_i), .lin_i(lin_i), .cken_ni(cken_ni),
    .adv_i(adv_i), .cs0_ni(cs0_ni), .cs1_i(cs1_i), .cs2_ni(cs2_ni), .rnw_i(rnw_i),
    .be_ni(be_ni), .addr_i(addr_i), .data_i(data_i), .oe_ni(oe_ni),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference: 0 idle, 1 read, 2 write; index 0 = newest command
  logic [DW-1:0] mem_m [DEPTH];
  int h_op [3];
  int h_addr [3];
  logic [NB-1:0] h_be [3];
  int last_m, base_m, cnt_m;
  bit flow_m;

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    for (int i = 0; i < 3; i++) begin h_op[i] = 0; h_addr[i] = 0; h_be[i] = '1; end
    last_m = 0; base_m = 0; cnt_m = 0; flow_m = flow_i;
  endtask

  task automatic model_edge();
    int lat, na, nop, low;
    lat = flow_m ? 1 : 2;
    if (h_op[lat-1] == 2)
      for (int b = 0; b < NB; b++)
        if (!h_be[lat-1][b]) mem_m[h_addr[lat-1]][b*BW +: BW] = data_i[b*BW +: BW];
    if (!adv_i) begin
      base_m = int'(addr_i); cnt_m = 0; na = base_m;
      nop = (!cs0_ni && cs1_i && !cs2_ni) ? (rnw_i ? 1 : 2) : 0;
    end else begin
      cnt_m = (cnt_m + 1) % 4;
      low = lin_i ? ((base_m % 4) + cnt_m) % 4 : ((base_m % 4) ^ cnt_m);
      na = (base_m / 4) * 4 + low;
      nop = last_m;
    end
    last_m = nop;
    for (int i = 2; i > 0; i--) begin h_op[i] = h_op[i-1]; h_addr[i] = h_addr[i-1]; h_be[i] = h_be[i-1]; end
    h_op[0] = nop; h_addr[0] = na; h_be[0] = be_ni;
  endtask

  task automatic compare();
    int lat;
    logic exp_oe;
    logic [DW-1:0] exp_d;
    lat = flow_m ? 1 : 2;
    exp_oe = !oe_ni && h_op[lat-1] == 1;
    exp_d = exp_oe ? mem_m[h_addr[lat-1]] : '0;
    vectors++;
    if (data_oe_o !== exp_oe || data_o !== exp_d) begin
      fails++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h at %0t",
               cur_req, data_oe_o, data_o, exp_oe, exp_d, $time);
    end
  endtask

  task automatic cyc(input bit ck_n, input bit adv_v, input bit c0, input bit c1, input bit c2,
                     input bit rnw_v, input logic [NB-1:0] be, input int a, input bit oe);
    cken_ni = ck_n; adv_i = adv_v; cs0_ni = c0; cs1_i = c1; cs2_ni = c2;
    rnw_i = rnw_v; be_ni = be; addr_i = AW'(a); oe_ni = oe;
    data_i = DW'($urandom);
    @(posedge clk);
    if (!cken_ni) model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input int a, input bit oe);
    cyc(0, 0, 0, 1, 0, 1, NB'($urandom), a, oe);
  endtask
  task automatic wr(input int a, input logic [NB-1:0] be);
    cyc(0, 0, 0, 1, 0, 0, be, a, 0);
  endtask
  task automatic adv(input logic [NB-1:0] be);  // garbage on ignored pins
    cyc(0, 1, 1, 0, 1, 1'($urandom), be, int'($urandom % DEPTH), 0);
  endtask
  task automatic stall();
    cyc(1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
        NB'($urandom), int'($urandom % DEPTH), 0);
  endtask
  task automatic dsel(input int which, input bit rnw_v);
    cyc(0, 0, which == 0, which != 1, which == 2, rnw_v, '0, int'($urandom % DEPTH), 0);
  endtask
  task automatic drain();
    for (int i = 0; i < 3; i++) dsel(i, 1);
  endtask

  task automatic do_reset(input bit fl);
    cur_req = "R1";
    rst_ni = 1'b0; flow_i = fl;
    cken_ni = 0; adv_i = 0; cs0_ni = 1; cs1_i = 0; cs2_ni = 1; oe_ni = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      model_reset(); compare();
    end
    rst_ni = 1'b1;
  endtask

  task automatic mixed(input int n);
    for (int i = 0; i < n; i++) begin
      case ($urandom % 7)
        0, 1: rd(int'($urandom % 16), ($urandom % 8) == 0);
        2, 3: wr(int'($urandom % 16), NB'($urandom));
        4:    adv(NB'($urandom));
        5:    stall();
        default: dsel(int'($urandom % 3), 1'($urandom));
      endcase
    end
  endtask

  task automatic suite();
    cur_req = "R1"; rd(5, 0); rd(63, 0); rd(0, 0); drain();
    cur_req = "R2"; wr(1, 2'b00); wr(2, 2'b00); wr(3, 2'b00); rd(1, 0); rd(2, 0); rd(3, 0); drain();
    cur_req = "R4"; wr(10, 2'b00); rd(1, 0); wr(11, 2'b00); rd(10, 0); rd(11, 0); wr(1, 2'b00); rd(1, 0); drain();
    cur_req = "R10"; wr(20, 2'b00); rd(20, 0); wr(20, 2'b01); rd(20, 0); wr(21, 2'b10); rd(21, 0); drain();
    cur_req = "R5"; wr(30, 2'b00); wr(30, 2'b10); wr(30, 2'b01); wr(31, 2'b11); rd(30, 0); rd(31, 0); drain();
    cur_req = "R6"; wr(40, 2'b00); dsel(0, 0); dsel(1, 0); dsel(2, 0); rd(40, 0);
    dsel(1, 1); rd(40, 0); cyc(0, 0, 0, 0, 0, 0, '0, 40, 0); rd(40, 0); adv('0); drain();
    cur_req = "R7"; lin_i = 1; wr(13, 2'b00); adv(2'b00); adv(2'b01); adv(2'b00);
    rd(14, 0); adv('0); adv('0); adv('0); adv('0); drain();
    lin_i = 0; wr(45, 2'b00); adv(2'b00); adv(2'b10); adv(2'b00);
    rd(46, 0); adv('0); adv('0); adv('0); dsel(0, 1); adv('0); adv('0); drain(); lin_i = 1;
    cur_req = "R8"; wr(50, 2'b00); stall(); stall(); rd(50, 0); stall(); wr(51, 2'b00); stall();
    rd(51, 0); stall(); stall(); rd(50, 0); adv('0); stall(); adv('0); drain();
    cur_req = "R9"; rd(1, 0); rd(2, 1); rd(3, 0); rd(1, 1); cyc(0, 0, 0, 1, 0, 0, '0, 2, 1);
    cyc(0, 0, 0, 1, 0, 1, '0, 2, 1); rd(2, 0); dsel(0, 1); oe_ni = 1; #0.1; drain();
    cur_req = "R4"; mixed(400); drain();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL %s: watchdog expired, actual hung expected done", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    do_reset(0);
    suite();
    do_reset(1);
    cur_req = "R3"; wr(7, 2'b00); rd(7, 0); wr(8, 2'b01); rd(8, 0); rd(7, 0); drain();
    suite();
    cur_req = "R11"; flow_i = 0; wr(9, 2'b00); rd(9, 0); rd(9, 0); mixed(100); drain();
    flow_i = 1;
    do_reset(0);
    cur_req = "R11"; flow_i = 1; wr(9, 2'b00); rd(9, 0); rd(9, 0); mixed(100); drain();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule